// File: doc/BRIEF.md
# I2C Master Transmit Controller

This block is the transmit half of an I2C bus master. A host reaches it through a small four-register map. The host selects master transmit operation, asks for a start condition, loads bytes one at a time, and asks for a stop condition. It follows progress by polling status flags. The first byte after a start carries the 7-bit slave address and the R/W bit. Later bytes are data. After each byte the block frees SDA for a ninth clock and records the level the slave returned.

Transmit data passes through a one-byte holding register that sits ahead of the shift register. The host can therefore load the next byte while the current one is still on the wire. A "buffer empty" flag tells the host the holding register is free. A separate "byte finished" flag tells it that a byte and its acknowledge clock are complete. SCL and SDA are open-drain. Each line has a pull-low enable output and a sampled input. SCL is derived from the system clock through a fixed divider: one bit time is four divider ticks.

The bus-busy bit follows start and stop conditions seen on the wire. A start request is accepted only while the bus is idle.

Top module: `i2c_mtx_ctrl`

## Requirements
- R1: After reset both line enables are 0 (lines released). STATUS (address 2) reads 0x80, and CTRL (address 0) and BUSCMD (address 1) read 0x00.
- R2: A write to BUSCMD with bit7=1 and bit6=1 is ignored. So is a write with bit7=1 while CTRL bit7 or bit6 is 0. In both cases no start condition appears on the bus and the busy bit stays 0.
- R3: A write to BUSCMD with bit7=1 and bit6=0, in master transmit mode on an idle bus, makes SDA fall while SCL is high. After that, BUSCMD bit7 (bus busy) reads 1.
- R4: Each byte goes out MSB first on eight SCL clocks, followed by a ninth clock. While a byte is being clocked, SDA changes only while SCL is low.
- R5: Writing TXDATA (address 3) clears STATUS bit7 (buffer empty). The bit returns to 1 as soon as the byte moves to the shift register, so the next byte can be written before the current one has finished.
- R6: STATUS bit6 (byte finished) becomes 1 after the acknowledge clock of each byte. A STATUS write with bit6=0 clears it.
- R7: SDA is released during the ninth clock. The level sampled while SCL is high is held in STATUS bit0: 0 means acknowledged, 1 means not acknowledged.
- R8: A write to BUSCMD with bit7=0 and bit6=0 while a transfer is open produces a stop condition (SDA rises while SCL is high) after the byte in progress. STATUS bit3 (stop seen) then becomes 1 and the busy bit returns to 0. A STATUS write with bit3=0 clears bit3.
- R9: CTRL bit7 (master) and bit6 (transmit) read back as written. Clearing both after a stop leaves the block idle in slave receive mode with both lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 2 | Register address: 0 CTRL, 1 BUSCMD, 2 STATUS, 3 TXDATA |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | Sampled SCL level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA level |

## Verification
The assertions check four things on every cycle. SDA must hold steady while SCL is released inside a byte. SDA must stay released through the acknowledge clock. The buffer-empty, byte-finished and stop-seen flags must follow their set and clear events. A detected start must raise the busy bit.

Other behaviour only the bench scenarios can show. These are that bytes reach a slave model MSB first and in order, that ignored start requests leave the bus untouched, that acknowledge and not-acknowledge are both captured, and that a second transfer works after a stop and a return to slave receive mode.

// File: rtl/i2c_mtx_pkg.sv
package i2c_mtx_pkg;

   localparam int BYTE_W = 8;
   localparam int ACK_IDX = BYTE_W;

   localparam logic [1:0] A_CTRL   = 2'd0;
   localparam logic [1:0] A_BUSCMD = 2'd1;
   localparam logic [1:0] A_STATUS = 2'd2;
   localparam logic [1:0] A_TXDATA = 2'd3;

   // bit positions inside the host registers
   localparam int B_MASTER = 7;
   localparam int B_XMIT   = 6;
   localparam int B_BUSY   = 7;
   localparam int B_SSCTL  = 6;
   localparam int B_EMPTY  = 7;
   localparam int B_TEND   = 6;
   localparam int B_STOPF  = 3;
   localparam int B_ACK    = 0;

   typedef enum logic [2:0] {
      ENG_IDLE,
      ENG_START,
      ENG_HOLD,
      ENG_BIT,
      ENG_STOP
   } eng_state_t;

endpackage

// File: rtl/i2c_mtx_tick.sv
module i2c_mtx_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || cnt == LAST) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign tick = run && (cnt == LAST);
endmodule

// File: rtl/i2c_mtx_busmon.sv
module i2c_mtx_busmon #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic start_det,
   output logic stop_det,
   output logic bus_busy
);
   logic scl_d, sda_d;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign scl_s = scl_in;
         assign sda_s = sda_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] scl_q, sda_q;
         for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_q[i] <= 1'b1;
                  sda_q[i] <= 1'b1;
               end else if (i == 0) begin
                  scl_q[i] <= scl_in;
                  sda_q[i] <= sda_in;
               end else begin
                  scl_q[i] <= scl_q[(i == 0) ? 0 : i-1];
                  sda_q[i] <= sda_q[(i == 0) ? 0 : i-1];
               end
            end
         end
         assign scl_s = scl_q[SYNC_STAGES-1];
         assign sda_s = sda_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign start_det = scl_s && scl_d && sda_d && !sda_s;
   assign stop_det  = scl_s && scl_d && !sda_d && sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_busy <= 1'b0;
      end else if (start_det) begin
         bus_busy <= 1'b1;
      end else if (stop_det) begin
         bus_busy <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_mtx_engine.sv
module i2c_mtx_engine
   import i2c_mtx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start_go,
   input  logic              stop_req,
   input  logic              buf_full,
   input  logic [BYTE_W-1:0] buf_data,
   input  logic              sda_s,
   output logic              load,
   output logic              byte_done,
   output logic              ack_val,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              idle,
   output logic              shifting,
   output logic              ack_window
);
   localparam int NW = $clog2(ACK_IDX + 1);
   localparam logic [NW-1:0] ACK_N = NW'(ACK_IDX);

   eng_state_t        state;
   logic [1:0]        q;
   logic [NW-1:0]     bitn;
   logic [BYTE_W-1:0] shreg;
   logic              stop_pend;

   assign idle       = (state == ENG_IDLE);
   assign shifting   = (state == ENG_BIT);
   assign ack_window = shifting && (bitn == ACK_N) && (q != 2'd0);
   assign load       = (state == ENG_HOLD) && !stop_pend && buf_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ENG_IDLE;
         q         <= 2'd0;
         bitn      <= '0;
         shreg     <= '0;
         stop_pend <= 1'b0;
         scl_oe    <= 1'b0;
         sda_oe    <= 1'b0;
         ack_val   <= 1'b0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (stop_req) stop_pend <= 1'b1;
         case (state)
            ENG_IDLE: begin
               if (start_go) begin
                  state <= ENG_START;
                  q     <= 2'd0;
               end
            end
            ENG_START: begin
               if (tick) begin
                  q <= q + 2'd1;
                  if (q == 2'd1) sda_oe <= 1'b1;
                  if (q == 2'd2) begin
                     scl_oe <= 1'b1;
                     state  <= ENG_HOLD;
                     q      <= 2'd0;
                  end
               end
            end
            ENG_HOLD: begin
               if (stop_pend) begin
                  state <= ENG_STOP;
                  q     <= 2'd0;
               end else if (buf_full) begin
                  shreg <= buf_data;
                  bitn  <= '0;
                  q     <= 2'd0;
                  state <= ENG_BIT;
               end
            end
            ENG_BIT: begin
               if (tick) begin
                  q <= q + 2'd1;
                  case (q)
                     2'd0: sda_oe <= (bitn == ACK_N) ? 1'b0 : ~shreg[BYTE_W-1];
                     2'd1: scl_oe <= 1'b0;
                     2'd2: if (bitn == ACK_N) ack_val <= sda_s;
                     default: begin
                        scl_oe <= 1'b1;
                        if (bitn == ACK_N) begin
                           byte_done <= 1'b1;
                           state     <= ENG_HOLD;
                        end else begin
                           shreg <= {shreg[BYTE_W-2:0], 1'b0};
                           bitn  <= bitn + 1'b1;
                        end
                     end
                  endcase
               end
            end
            ENG_STOP: begin
               if (tick) begin
                  q <= q + 2'd1;
                  case (q)
                     2'd0: sda_oe <= 1'b1;
                     2'd1: scl_oe <= 1'b0;
                     2'd2: sda_oe <= 1'b0;
                     default: begin
                        state     <= ENG_IDLE;
                        stop_pend <= 1'b0;
                     end
                  endcase
               end
            end
            default: state <= ENG_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/i2c_mtx_regs.sv
module i2c_mtx_regs
   import i2c_mtx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [1:0]        host_addr,
   input  logic [BYTE_W-1:0] host_wdata,
   output logic [BYTE_W-1:0] host_rdata,
   input  logic              load,
   input  logic              byte_done,
   input  logic              ack_val,
   input  logic              bus_busy,
   input  logic              stop_det,
   input  logic              eng_idle,
   output logic              start_go,
   output logic              stop_req,
   output logic              buf_full,
   output logic [BYTE_W-1:0] buf_data,
   output logic              tx_end,
   output logic              stop_flag
);
   logic mst, trs;
   logic wr_ctrl, wr_cmd, wr_stat, wr_data;

   assign wr_ctrl = host_we && (host_addr == A_CTRL);
   assign wr_cmd  = host_we && (host_addr == A_BUSCMD);
   assign wr_stat = host_we && (host_addr == A_STATUS);
   assign wr_data = host_we && (host_addr == A_TXDATA);

   assign start_go = wr_cmd && host_wdata[B_BUSY] && !host_wdata[B_SSCTL]
                     && mst && trs && !bus_busy && eng_idle;
   assign stop_req = wr_cmd && !host_wdata[B_BUSY] && !host_wdata[B_SSCTL] && !eng_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mst       <= 1'b0;
         trs       <= 1'b0;
         buf_full  <= 1'b0;
         buf_data  <= '0;
         tx_end    <= 1'b0;
         stop_flag <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            mst <= host_wdata[B_MASTER];
            trs <= host_wdata[B_XMIT];
         end
         if (wr_data) begin
            buf_data <= host_wdata;
            buf_full <= 1'b1;
         end else if (load) begin
            buf_full <= 1'b0;
         end
         if (byte_done) tx_end <= 1'b1;
         else if (wr_stat && !host_wdata[B_TEND]) tx_end <= 1'b0;
         if (stop_det) stop_flag <= 1'b1;
         else if (wr_stat && !host_wdata[B_STOPF]) stop_flag <= 1'b0;
      end
   end

   always_comb begin
      host_rdata = '0;
      case (host_addr)
         A_CTRL: begin
            host_rdata[B_MASTER] = mst;
            host_rdata[B_XMIT]   = trs;
         end
         A_BUSCMD: host_rdata[B_BUSY] = bus_busy;
         A_STATUS: begin
            host_rdata[B_EMPTY] = !buf_full;
            host_rdata[B_TEND]  = tx_end;
            host_rdata[B_STOPF] = stop_flag;
            host_rdata[B_ACK]   = ack_val;
         end
         default: host_rdata = buf_data;
      endcase
   end
endmodule

// File: rtl/i2c_mtx_ctrl.sv
module i2c_mtx_ctrl #(
   parameter int CLK_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_we,
   input  logic [1:0] host_addr,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata,
   output logic       scl_oe,
   input  logic       scl_in,
   output logic       sda_oe,
   input  logic       sda_in
);
   import i2c_mtx_pkg::*;

   generate
      if (CLK_DIV < SYNC_STAGES + 2) begin : g_bad_div
         $error("CLK_DIV must exceed SYNC_STAGES + 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic tick, eng_idle, start_go, stop_req, load, byte_done, ack_val;
   logic buf_full, tx_end, stop_flag, tx_empty;
   logic scl_s, sda_s, start_det, stop_det, bus_busy;
   logic shifting, ack_window;
   logic [BYTE_W-1:0] buf_data;

   assign tx_empty = !buf_full;

   i2c_mtx_tick #(.DIV(CLK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(!eng_idle), .tick(tick)
   );

   i2c_mtx_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_s(scl_s), .sda_s(sda_s), .start_det(start_det),
      .stop_det(stop_det), .bus_busy(bus_busy)
   );

   i2c_mtx_regs u_regs (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .load(load),
      .byte_done(byte_done), .ack_val(ack_val), .bus_busy(bus_busy),
      .stop_det(stop_det), .eng_idle(eng_idle), .start_go(start_go),
      .stop_req(stop_req), .buf_full(buf_full), .buf_data(buf_data),
      .tx_end(tx_end), .stop_flag(stop_flag)
   );

   i2c_mtx_engine u_eng (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start_go(start_go),
      .stop_req(stop_req), .buf_full(buf_full), .buf_data(buf_data),
      .sda_s(sda_s), .load(load), .byte_done(byte_done), .ack_val(ack_val),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .idle(eng_idle),
      .shifting(shifting), .ack_window(ack_window)
   );
endmodule

// File: rtl/i2c_mtx_chk.sv
module i2c_mtx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       host_we,
   input logic [1:0] host_addr,
   input logic [7:0] host_wdata,
   input logic       scl_oe,
   input logic       sda_oe,
   input logic       tx_empty,
   input logic       tx_end,
   input logic       stop_flag,
   input logic       byte_done,
   input logic       shifting,
   input logic       ack_window,
   input logic       start_det,
   input logic       stop_det,
   input logic       bus_busy
);
   p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> bus_busy);

   p_sda_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (shifting && $past(shifting) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

   p_empty_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_addr == 2'd3) |=> !tx_empty);

   p_tend_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> tx_end);

   p_tend_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_addr == 2'd2 && !host_wdata[6] && !byte_done) |=> !tx_end);

   p_ack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_window |-> !sda_oe);

   p_stop_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (stop_flag && !bus_busy));
endmodule

bind i2c_mtx_ctrl i2c_mtx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
   .host_wdata(host_wdata), .scl_oe(scl_oe), .sda_oe(sda_oe),
   .tx_empty(tx_empty), .tx_end(tx_end), .stop_flag(stop_flag),
   .byte_done(byte_done), .shifting(shifting), .ack_window(ack_window),
   .start_det(start_det), .stop_det(stop_det), .bus_busy(bus_busy)
);

// File: tb/i2c_mtx_ctrl_test.sv
module i2c_mtx_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_we = 1'b0;
   logic [1:0] host_addr = 2'd0;
   logic [7:0] host_wdata = 8'd0;
   logic [7:0] host_rdata;
   logic       scl_oe, sda_oe;
   logic       slv_drive = 1'b0;
   logic       ack_en = 1'b1;
   wire        scl_ln = ~scl_oe;
   wire        sda_ln = ~(sda_oe | slv_drive);

   int checks = 0;
   int fails  = 0;
   int starts = 0;
   int stops  = 0;
   logic [7:0] exp_q[$];

   always #2 clk = ~clk;

   i2c_mtx_ctrl uut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .scl_oe(scl_oe),
      .scl_in(scl_ln), .sda_oe(sda_oe), .sda_in(sda_ln)
   );

   task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic wait_bit(input logic [1:0] a, input int b, input logic v, input string tag);
      logic [7:0] d;
      int n = 0;
      do begin
         rd(a, d);
         n++;
      end while (d[b] !== v && n < 3000);
      chk(d[b] === v, tag, {7'd0, d[b]}, {7'd0, v});
   endtask

   // driver: load a byte and record it for the monitor
   task automatic send(input logic [7:0] b);
      exp_q.push_back(b);
      wr(2'd3, b);
   endtask

   // bus monitor and slave model
   logic prev_scl = 1'b1, prev_sda = 1'b1;
   int   bitpos = 0;
   logic [7:0] rx = 8'd0;
   always @(scl_ln or sda_ln) begin
      if (scl_ln && prev_scl && prev_sda && !sda_ln) begin
         starts++; bitpos = 0;
      end else if (scl_ln && prev_scl && !prev_sda && sda_ln) begin
         stops++; bitpos = 0;
      end else if (scl_ln && !prev_scl) begin
         if (bitpos < 8) begin
            rx = {rx[6:0], sda_ln};
            bitpos++;
            if (bitpos == 8) begin
               if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte", rx, 8'hxx);
               else begin
                  logic [7:0] e;
                  e = exp_q.pop_front();
                  chk(rx === e, "R4 byte on bus", rx, e);
               end
            end
         end else begin
            bitpos = 0;
         end
      end else if (!scl_ln && prev_scl) begin
         slv_drive = (bitpos == 8) && ack_en;
      end
      prev_scl = scl_ln;
      prev_sda = sda_ln;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] d;
      int s0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      chk(scl_oe === 1'b0 && sda_oe === 1'b0, "R1 lines released", {6'd0, scl_oe, sda_oe}, 8'h00);
      rd(2'd2, d); chk(d === 8'h80, "R1 STATUS", d, 8'h80);
      rd(2'd0, d); chk(d === 8'h00, "R1 CTRL", d, 8'h00);
      rd(2'd1, d); chk(d === 8'h00, "R1 BUSCMD", d, 8'h00);

      // R2 start while not in master transmit mode
      wr(2'd1, 8'h80);
      repeat (60) @(negedge clk);
      rd(2'd1, d); chk(d === 8'h00 && starts == 0, "R2 start ignored out of mode", d, 8'h00);

      // R9 mode bits read back
      wr(2'd0, 8'hC0);
      rd(2'd0, d); chk(d === 8'hC0, "R9 CTRL readback", d, 8'hC0);

      // R2 start with control bit set
      wr(2'd1, 8'hC0);
      repeat (60) @(negedge clk);
      rd(2'd1, d); chk(d === 8'h00 && starts == 0, "R2 start ignored with bit6", d, 8'h00);

      // R3 start
      wr(2'd1, 8'h80);
      wait_bit(2'd1, 7, 1'b1, "R3 busy after start");
      chk(starts == 1, "R3 start on bus", 8'(starts), 8'd1);

      // R5 double buffering
      ack_en = 1'b1;
      send(8'hA4);
      wait_bit(2'd2, 7, 1'b1, "R5 empty after move to shifter");
      send(8'h3C);
      rd(2'd2, d);
      chk(d[7] === 1'b0 && d[6] === 1'b0, "R5 second byte buffered before end", d & 8'hC0, 8'h00);

      // R6/R7 first byte acked
      wait_bit(2'd2, 6, 1'b1, "R6 byte finished");
      rd(2'd2, d); chk(d[0] === 1'b0, "R7 ack latched", {7'd0, d[0]}, 8'h00);
      wr(2'd2, 8'h08);
      rd(2'd2, d); chk(d[6] === 1'b0, "R6 cleared by write 0", {7'd0, d[6]}, 8'h00);
      wait_bit(2'd2, 6, 1'b1, "R6 second byte finished");
      wr(2'd2, 8'h08);

      // R7 not acknowledged
      ack_en = 1'b0;
      send(8'h81);
      wait_bit(2'd2, 6, 1'b1, "R6 third byte finished");
      rd(2'd2, d); chk(d[0] === 1'b1, "R7 nack latched", {7'd0, d[0]}, 8'h01);
      wr(2'd2, 8'h08);

      // R8 stop
      s0 = stops;
      wr(2'd1, 8'h00);
      wait_bit(2'd2, 3, 1'b1, "R8 stop flag");
      rd(2'd1, d); chk(d === 8'h00, "R8 busy cleared", d, 8'h00);
      chk(stops == s0 + 1, "R8 stop on bus", 8'(stops - s0), 8'd1);
      wr(2'd2, 8'h40);
      rd(2'd2, d); chk(d[3] === 1'b0, "R8 stop flag cleared", {7'd0, d[3]}, 8'h00);

      // R9 back to slave receive
      wr(2'd0, 8'h00);
      repeat (20) @(negedge clk);
      rd(2'd0, d); chk(d === 8'h00, "R9 CTRL cleared", d, 8'h00);
      chk(scl_oe === 1'b0 && sda_oe === 1'b0, "R9 lines idle", {6'd0, scl_oe, sda_oe}, 8'h00);

      // second transfer with boundary data
      ack_en = 1'b1;
      wr(2'd0, 8'hC0);
      wr(2'd1, 8'h80);
      wait_bit(2'd1, 7, 1'b1, "R3 busy second start");
      send(8'h00);
      wait_bit(2'd2, 7, 1'b1, "R5 empty second transfer");
      send(8'hFF);
      wait_bit(2'd2, 6, 1'b1, "R6 finished second transfer");
      wr(2'd2, 8'h08);
      wait_bit(2'd2, 6, 1'b1, "R6 finished last byte");
      rd(2'd2, d); chk(d[0] === 1'b0, "R7 ack on last byte", {7'd0, d[0]}, 8'h00);
      wr(2'd1, 8'h00);
      wait_bit(2'd2, 3, 1'b1, "R8 stop flag second");
      chk(starts == 2 && stops == 2, "R8 conditions counted", 8'(starts + stops), 8'd4);
      chk(exp_q.size() == 0, "R4 all bytes seen", 8'(exp_q.size()), 8'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule